// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive side of a frame DMA engine. Software builds a closed ring of descriptors in host memory. Each descriptor is four 32-bit words, in this order: status at +0, control at +4, buffer pointer at +8 and link pointer at +12. The engine reads the current descriptor through a single-outstanding memory port. If the descriptor is owned by the engine, it stores the bytes of the next frame into that descriptor's buffer, one strobed byte write per byte. It then writes one status word, which also hands the descriptor back to software, and follows the link pointer. A frame that is larger than one buffer continues into the descriptors that follow.

Software starts the engine by writing the ring base. If the engine reaches a descriptor it does not own, it drops frames and raises a buffer-unavailable flag. A poll-demand pulse from software makes it read the same descriptor again. Each completed frame can request an interrupt through a control bit of the descriptor.

The controller has nine states:
- `S_IDLE`: the state after reset. It discards incoming bytes and has no ring yet.
- `S_FETCH_ST`, `S_FETCH_CTL`, `S_FETCH_BUF`, `S_FETCH_NXT`: these read the four descriptor words in turn.
- `S_READY`: accepts the next byte.
- `S_WRITE`: stores that byte.
- `S_CLOSE`: writes the status word back.
- `S_STALL`: discards bytes while no descriptor is available.

The transitions are as follows:
- Any state goes to `S_FETCH_ST` on a base write.
- `S_FETCH_ST` goes to `S_FETCH_CTL` when the ownership bit is set, and to `S_STALL` when it is clear.
- Each of the other fetch states advances to the next fetch state on acknowledge. `S_FETCH_NXT` advances to `S_READY`.
- `S_READY` goes to `S_WRITE` when a byte arrives.
- `S_WRITE` goes to `S_CLOSE` on the frame's last byte or when the buffer is full. Otherwise it returns to `S_READY`.
- `S_CLOSE` goes to `S_FETCH_ST` after the status write.
- `S_STALL` goes to `S_FETCH_ST` when a poll is pending, no frame is in progress and no byte is offered.

Top module: `rxring_dma`

## Requirements
- R1: After reset, `mem_req`, `buf_unavail` and `rx_irq` are low. Until the ring base is written, the engine accepts and discards all incoming bytes and makes no memory request.
- R2: A pulse on `base_wr` makes the descriptor at `base_addr` the current one. The next frame lands there.
- R3: The engine fills a descriptor only when it read bit 31 of that descriptor's status word as 1. Every status word it writes back has bit 31 = 0.
- R4: The final status word of a frame holds, in bits 27:16, the count of all bytes delivered for the frame, trailing CRC bytes included. Other status words have 0 there.
- R5: Status bit 11 is set only in the first descriptor of a frame, and bit 10 only in its last. A frame that fits one buffer sets both.
- R6: The final status word marks the address match from `rx_match`, which is sampled with the last byte. Code 1 (own address) sets bit 12, code 2 (broadcast) sets bit 13, code 3 (multicast) sets bit 14, and code 0 sets none.
- R7: In the final status word, `rx_err[4:0]` (runt, too long, alignment, CRC, receive error), sampled with the last byte, appear in bits 6:2 in that order. Bit 7 is set exactly when any of them is set.
- R8: Byte k of a segment is written to address buffer pointer + k, with exactly one write-strobe lane active.
- R9: Control bits 10:0 give the buffer size in bytes. A larger frame continues into the following descriptors, and a frame that exactly fills a buffer uses only that one.
- R10: After a descriptor is released, the engine continues at its link pointer. A ring whose last link points to the first wraps around.
- R11: Reading a status word with bit 31 clear raises `buf_unavail`. Frames arriving then are dropped without any memory write. A `poll_demand` pulse clears the flag, and the descriptor is read again once no frame is in progress.
- R12: `rx_irq` pulses for one cycle after the final status write of a frame, when control bit 23 of that last descriptor is set. It does not pulse for the other segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_wr | input | 1 | Ring base write strobe |
| base_addr | input | ADDR_W | Byte address of the first descriptor |
| poll_demand | input | 1 | Request to read the current descriptor again |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Engine takes the byte this cycle |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_match | input | 2 | Address match code, valid with the last byte |
| rx_err | input | 5 | Error flags, valid with the last byte |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte lane write strobes |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on a read |
| buf_unavail | output | 1 | Current descriptor not owned by the engine |
| rx_irq | output | 1 | Frame completion interrupt pulse |

## Verification
The assertions assume the following about software and the memory side:
- A memory request is answered only by `mem_ack`.
- `base_wr` comes only between frames.
- Every buffer size is nonzero and descriptors are word aligned.
- `rx_match` and `rx_err` are meaningful only with the last byte.

The stimulus keeps to these rules. Frames are sent whole, and the base is written only while `rx_valid` is low. Acknowledges come after random delays. Descriptors are always laid out with nonzero sizes at word-aligned addresses. Frame lengths, match codes and error sets are drawn at random, alongside directed cases:
- exact buffer fill
- a three-way split
- wrap-around
- a non-owned descriptor recovered by a poll

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH_ST,
        S_FETCH_CTL,
        S_FETCH_BUF,
        S_FETCH_NXT,
        S_READY,
        S_WRITE,
        S_CLOSE,
        S_STALL
    } rx_state_t;

    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / 8;
    localparam int FLEN_W     = 12;
    localparam int ERR_W      = 5;
    localparam int ST_OWN     = 31;
    localparam int ST_LEN_LSB = 16;
    localparam int ST_MCAST   = 14;
    localparam int ST_BCAST   = 13;
    localparam int ST_UCAST   = 12;
    localparam int ST_FIRST   = 11;
    localparam int ST_LAST    = 10;
    localparam int ST_SUMMARY = 7;
    localparam int ST_ERR_LSB = 2;
    localparam int CT_IRQ     = 23;

    localparam logic [1:0] MATCH_NONE  = 2'd0;
    localparam logic [1:0] MATCH_OWN   = 2'd1;
    localparam logic [1:0] MATCH_BCAST = 2'd2;
    localparam logic [1:0] MATCH_MCAST = 2'd3;
endpackage

// File: rtl/rxr_status_pack.sv
module rxr_status_pack
    import rxr_pkg::*;
(
    input  logic                 first_seg,
    input  logic                 last_seg,
    input  logic [FLEN_W-1:0]    frame_len,
    input  logic [1:0]           match_code,
    input  logic [ERR_W-1:0]     err_flags,
    output logic [WORD_W-1:0]    status_word
);
    always_comb begin
        status_word = '0;
        status_word[ST_FIRST] = first_seg;
        status_word[ST_LAST]  = last_seg;
        if (last_seg) begin
            status_word[ST_LEN_LSB +: FLEN_W] = frame_len;
            status_word[ST_UCAST]   = (match_code == MATCH_OWN);
            status_word[ST_BCAST]   = (match_code == MATCH_BCAST);
            status_word[ST_MCAST]   = (match_code == MATCH_MCAST);
            status_word[ST_ERR_LSB +: ERR_W] = err_flags;
            status_word[ST_SUMMARY] = |err_flags;
        end
    end
endmodule

// File: rtl/rxr_byte_lane.sv
module rxr_byte_lane
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 11
) (
    input  logic [ADDR_W-1:0] buf_ptr,
    input  logic [OFF_W-1:0]  offset,
    input  logic [7:0]        byte_in,
    output logic [ADDR_W-1:0] word_addr,
    output logic [LANES-1:0]  strobe,
    output logic [WORD_W-1:0] wdata
);
    localparam int SEL_W = $clog2(LANES);
    logic [ADDR_W-1:0] byte_addr;

    assign byte_addr = buf_ptr + ADDR_W'(offset);
    assign word_addr = {byte_addr[ADDR_W-1:SEL_W], {SEL_W{1'b0}}};

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign strobe[ln]          = (byte_addr[SEL_W-1:0] == SEL_W'(ln));
        assign wdata[8*ln +: 8]    = byte_in;
    end
endmodule

// File: rtl/rxr_desc_regs.sv
module rxr_desc_regs
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BSZ_W  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_wr,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic               ld_ctl,
    input  logic               ld_buf,
    input  logic               ld_nxt,
    input  logic               advance,
    input  logic [WORD_W-1:0]  rdata,
    output logic [ADDR_W-1:0]  cur_ptr,
    output logic [ADDR_W-1:0]  buf_ptr,
    output logic [BSZ_W-1:0]   buf_size,
    output logic               irq_en
);
    logic [ADDR_W-1:0] link_ptr;
    wire unused_ctl_bits = ^{rdata[WORD_W-1:CT_IRQ+1], rdata[CT_IRQ-1:BSZ_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ptr  <= '0;
            buf_ptr  <= '0;
            link_ptr <= '0;
            buf_size <= '0;
            irq_en   <= 1'b0;
        end else begin
            if (base_wr) begin
                cur_ptr <= base_addr;
            end else if (advance) begin
                cur_ptr <= link_ptr;
            end
            if (ld_ctl) begin
                buf_size <= rdata[BSZ_W-1:0];
                irq_en   <= rdata[CT_IRQ];
            end
            if (ld_buf) buf_ptr  <= ADDR_W'(rdata);
            if (ld_nxt) link_ptr <= ADDR_W'(rdata);
        end
    end
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BSZ_W  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_wr,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic               poll_demand,
    input  logic               rx_valid,
    output logic               rx_ready,
    input  logic [7:0]         rx_data,
    input  logic               rx_last,
    input  logic [1:0]         rx_match,
    input  logic [4:0]         rx_err,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [31:0]        mem_wdata,
    output logic [3:0]         mem_wstrb,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata,
    output logic               buf_unavail,
    output logic               rx_irq
);
    localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_BUF = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFS_NXT = ADDR_W'(12);

    rx_state_t state, state_nx;

    logic [BSZ_W-1:0]   seg_off;
    logic [FLEN_W-1:0]  frm_len;
    logic               first_seg;
    logic               mid_frame;
    logic               poll_pend;
    logic               owned_ok;
    logic               close_last;
    logic [7:0]         byte_q;
    logic               last_q;
    logic [1:0]         match_q;
    logic [ERR_W-1:0]   err_q;

    logic [ADDR_W-1:0]  cur_ptr, buf_ptr, lane_addr;
    logic [BSZ_W-1:0]   buf_size;
    logic               irq_en;
    logic [LANES-1:0]   lane_strb;
    logic [WORD_W-1:0]  lane_data, status_word;
    logic               seg_full;
    logic               acked;

    assign acked    = mem_req && mem_ack;
    assign seg_full = ({1'b0, seg_off} + 1'b1) == {1'b0, buf_size};

    rxr_desc_regs #(.ADDR_W(ADDR_W), .BSZ_W(BSZ_W)) u_desc (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_wr   (base_wr),
        .base_addr (base_addr),
        .ld_ctl    (state == S_FETCH_CTL && acked),
        .ld_buf    (state == S_FETCH_BUF && acked),
        .ld_nxt    (state == S_FETCH_NXT && acked),
        .advance   (state == S_CLOSE && acked),
        .rdata     (mem_rdata),
        .cur_ptr   (cur_ptr),
        .buf_ptr   (buf_ptr),
        .buf_size  (buf_size),
        .irq_en    (irq_en)
    );

    rxr_byte_lane #(.ADDR_W(ADDR_W), .OFF_W(BSZ_W)) u_lane (
        .buf_ptr   (buf_ptr),
        .offset    (seg_off),
        .byte_in   (byte_q),
        .word_addr (lane_addr),
        .strobe    (lane_strb),
        .wdata     (lane_data)
    );

    rxr_status_pack u_pack (
        .first_seg   (first_seg),
        .last_seg    (close_last),
        .frame_len   (frm_len),
        .match_code  (match_q),
        .err_flags   (err_q),
        .status_word (status_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      state_nx = S_IDLE;
            S_FETCH_ST:  if (acked) state_nx = mem_rdata[ST_OWN] ? S_FETCH_CTL : S_STALL;
            S_FETCH_CTL: if (acked) state_nx = S_FETCH_BUF;
            S_FETCH_BUF: if (acked) state_nx = S_FETCH_NXT;
            S_FETCH_NXT: if (acked) state_nx = S_READY;
            S_READY:     if (rx_valid) state_nx = S_WRITE;
            S_WRITE:     if (acked) state_nx = (last_q || seg_full) ? S_CLOSE : S_READY;
            S_CLOSE:     if (acked) state_nx = S_FETCH_ST;
            S_STALL:     if (poll_pend && !mid_frame && !rx_valid) state_nx = S_FETCH_ST;
            default:     state_nx = S_IDLE;
        endcase
        if (base_wr) state_nx = S_FETCH_ST;
    end

    // frame and segment bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_off     <= '0;
            frm_len     <= '0;
            first_seg   <= 1'b1;
            mid_frame   <= 1'b0;
            poll_pend   <= 1'b0;
            owned_ok    <= 1'b0;
            close_last  <= 1'b0;
            byte_q      <= '0;
            last_q      <= 1'b0;
            match_q     <= MATCH_NONE;
            err_q       <= '0;
            buf_unavail <= 1'b0;
            rx_irq      <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (base_wr) begin
                seg_off     <= '0;
                frm_len     <= '0;
                first_seg   <= 1'b1;
                mid_frame   <= 1'b0;
                poll_pend   <= 1'b0;
                owned_ok    <= 1'b0;
                buf_unavail <= 1'b0;
            end else begin
                unique case (state)
                    S_FETCH_ST: if (acked) begin
                        owned_ok <= mem_rdata[ST_OWN];
                        if (!mem_rdata[ST_OWN]) buf_unavail <= 1'b1;
                    end
                    S_READY: if (rx_valid) begin
                        byte_q  <= rx_data;
                        last_q  <= rx_last;
                        match_q <= rx_match;
                        err_q   <= rx_err;
                    end
                    S_WRITE: if (acked) begin
                        seg_off    <= seg_off + 1'b1;
                        frm_len    <= frm_len + 1'b1;
                        mid_frame  <= !last_q;
                        close_last <= last_q;
                    end
                    S_CLOSE: if (acked) begin
                        seg_off  <= '0;
                        owned_ok <= 1'b0;
                        rx_irq   <= close_last && irq_en;
                        if (close_last) begin
                            frm_len   <= '0;
                            first_seg <= 1'b1;
                        end else begin
                            first_seg <= 1'b0;
                        end
                    end
                    S_STALL: begin
                        if (rx_valid) begin
                            mid_frame <= !rx_last;
                            if (rx_last) begin
                                frm_len   <= '0;
                                first_seg <= 1'b1;
                            end
                        end
                        if (poll_demand) begin
                            poll_pend   <= 1'b1;
                            buf_unavail <= 1'b0;
                        end
                        if (state_nx == S_FETCH_ST) poll_pend <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_ptr;
        mem_wdata = '0;
        mem_wstrb = '0;
        rx_ready  = 1'b0;
        unique case (state)
            S_IDLE:      rx_ready = 1'b1;
            S_FETCH_ST:  mem_req = 1'b1;
            S_FETCH_CTL: begin mem_req = 1'b1; mem_addr = cur_ptr + OFS_CTL; end
            S_FETCH_BUF: begin mem_req = 1'b1; mem_addr = cur_ptr + OFS_BUF; end
            S_FETCH_NXT: begin mem_req = 1'b1; mem_addr = cur_ptr + OFS_NXT; end
            S_READY:     rx_ready = 1'b1;
            S_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lane_addr;
                mem_wdata = lane_data;
                mem_wstrb = lane_strb;
            end
            S_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = status_word;
                mem_wstrb = '1;
            end
            S_STALL:     rx_ready = 1'b1;
            default: ;
        endcase
    end

    // R8: a pending request keeps its address until acknowledged
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !base_wr) |=> (mem_req && $stable(mem_addr)));

    // R8: one byte lane per data write
    p_one_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && state == S_WRITE) |-> $countones(mem_wstrb) == 1);

    // R3: data is written only into a descriptor read as owned
    p_fill_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE) |-> owned_ok);

    // R3: written-back status never keeps the ownership bit
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CLOSE && mem_req) |-> !mem_wdata[ST_OWN]);

    // R11: the unavailable flag drops only on poll or base write
    p_unavail_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_unavail) |-> $past(poll_demand || base_wr));

    // R11: no memory traffic while stalled
    p_stall_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STALL) |-> !mem_req);

    // R12: interrupt follows a completed status write
    p_irq_origin_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(state == S_CLOSE && mem_ack));
endmodule

// File: tb/rxring_dma_tb.sv
module rxring_dma_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 1024;
    localparam int WDOG_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_addr = '0;
    logic        poll_demand = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic [1:0]  rx_match = '0;
    logic [4:0]  rx_err = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_wstrb;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        buf_unavail, rx_irq;

    logic [31:0] mem [MEM_WORDS];
    logic        tb_we = 1'b0;
    logic [31:0] tb_addr = '0, tb_data = '0;

    int checks = 0, errors = 0;
    int req_cnt = 0, irq_cnt = 0, cyc = 0;
    bit done = 0;

    int r_base, r_bufbase, r_n, r_bsz, r_idx;
    logic [7:0] fbytes [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxring_dma u_dut (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_addr(base_addr),
        .poll_demand(poll_demand), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_last(rx_last), .rx_match(rx_match), .rx_err(rx_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wstrb(mem_wstrb), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .buf_unavail(buf_unavail), .rx_irq(rx_irq)
    );

    // memory model
    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ack)
            for (int l = 0; l < 4; l++)
                if (mem_wstrb[l]) mem[mem_addr[11:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
        if (tb_we) mem[tb_addr[11:2]] <= tb_data;
        if (mem_req) req_cnt <= req_cnt + 1;
        if (rx_irq)  irq_cnt <= irq_cnt + 1;
        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        mem_ack   <= mem_req && (($urandom & 3) != 0);
        mem_rdata <= mem[mem_addr[11:2]];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_byte(input int a);
        logic [31:0] w;
        w = mem[a[11:2]];
        return w[8*(a%4) +: 8];
    endfunction

    function automatic logic [31:0] exp_status(input bit first, input bit last,
            input int len, input logic [1:0] m, input logic [4:0] e);
        logic [31:0] s;
        s = '0;
        if (first) s[11] = 1'b1;
        if (last) begin
            s[10] = 1'b1;
            s[27:16] = len[11:0];
            if (m != 2'd0) s[11 + m] = 1'b1;
            s[6:2] = e;
            s[7] = |e;
        end
        return s;
    endfunction

    task automatic poke(input int a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = a; tb_data = d;
        @(posedge clk);
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rearm(input int idx, input bit own);
        poke(r_base + 16*idx, own ? 32'h8000_0000 : 32'h0);
        for (int w = 0; w < 16; w++) poke(r_bufbase + 64*idx + 4*w, 32'hEEEE_EEEE);
    endtask

    task automatic setup_ring(input int base, input int bufbase, input int n,
            input int bsz, input bit irq, input bit own0);
        r_base = base; r_bufbase = bufbase; r_n = n; r_bsz = bsz; r_idx = 0;
        for (int i = 0; i < n; i++) begin
            poke(base + 16*i + 4, (irq ? 32'h0080_0000 : 32'h0) | bsz);
            poke(base + 16*i + 8, bufbase + 64*i);
            poke(base + 16*i + 12, base + 16*((i + 1) % n));
            rearm(i, (i == 0) ? own0 : 1'b1);
        end
        @(negedge clk);
        base_wr = 1'b1; base_addr = base;
        @(negedge clk);
        base_wr = 1'b0;
        wait_cycles(20);
    endtask

    task automatic send_frame(input int len, input logic [1:0] m, input logic [4:0] e);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = fbytes[i]; rx_last = (i == len - 1);
            rx_match = m; rx_err = e;
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic run_frame(input int len, input logic [1:0] m, input logic [4:0] e,
            input string tag);
        int off, segs;
        for (int i = 0; i < len; i++) fbytes[i] = 8'($urandom);
        send_frame(len, m, e);
        wait_cycles(40);
        off = 0; segs = 0;
        while (off < len) begin
            int idx, sl, mism;
            bit last;
            idx  = (r_idx + segs) % r_n;
            sl   = (len - off < r_bsz) ? len - off : r_bsz;
            last = (off + sl == len);
            check({tag, " R3 R4 R5 R6 R7 status"}, mem[(r_base + 16*idx) >> 2],
                  exp_status(segs == 0, last, len, m, e));
            mism = 0;
            for (int k = 0; k < sl; k++)
                if (rd_byte(r_bufbase + 64*idx + k) !== fbytes[off + k]) mism++;
            check({tag, " R8 bytes"}, mism, 0);
            off += sl; segs++;
        end
        for (int s = 0; s < segs; s++) rearm((r_idx + s) % r_n, 1'b1);
        r_idx = (r_idx + segs) % r_n;
    endtask

    // watchdog
    initial begin
        wait (cyc >= WDOG_LIMIT);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ic;
        void'($urandom(32'd7341));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        wait_cycles(3);
        check("R1 reset mem_req", mem_req, 0);
        check("R1 reset buf_unavail", buf_unavail, 0);
        check("R1 reset rx_irq", rx_irq, 0);
        rst_n = 1'b1;
        wait_cycles(2);
        for (int i = 0; i < 6; i++) fbytes[i] = 8'(i);
        send_frame(6, 2'd1, 5'd0);
        wait_cycles(5);
        check("R1 no request before base", req_cnt, 0);

        // R2 R3..R8: ring A, big buffers
        setup_ring(32'h100, 32'h400, 4, 64, 1'b0, 1'b1);
        run_frame(10, 2'd1, 5'b00000, "R2 own match");
        run_frame(12, 2'd2, 5'b00010, "crc err");
        run_frame(20, 2'd3, 5'b10001, "runt rxerr");
        run_frame(5, 2'd0, 5'b01100, "long align");
        run_frame(7, 2'd1, 5'd0, "R10 wrap");

        // R9 split and exact fill, R2 new base
        setup_ring(32'h200, 32'h700, 4, 8, 1'b0, 1'b1);
        run_frame(20, 2'd2, 5'd0, "R9 R2 split three");
        run_frame(8, 2'd1, 5'd0, "R9 exact fill");
        run_frame(9, 2'd3, 5'b00100, "R9 R10 split wrap");

        // R12 interrupts
        setup_ring(32'h300, 32'h400, 4, 16, 1'b1, 1'b1);
        ic = irq_cnt;
        run_frame(6, 2'd1, 5'd0, "R12 single");
        check("R12 one pulse single", irq_cnt - ic, 1);
        ic = irq_cnt;
        run_frame(40, 2'd1, 5'd0, "R12 multi");
        check("R12 one pulse for three segments", irq_cnt - ic, 1);

        // R11 not owned
        setup_ring(32'h100, 32'h600, 4, 32, 1'b0, 1'b0);
        check("R11 unavail raised", buf_unavail, 1);
        ic = req_cnt;
        for (int i = 0; i < 9; i++) fbytes[i] = 8'hA0 + 8'(i);
        send_frame(9, 2'd1, 5'd0);
        wait_cycles(10);
        check("R11 no traffic while stalled", req_cnt - ic, 0);
        check("R11 buffer untouched", mem[32'h600 >> 2], 32'hEEEE_EEEE);
        check("R11 status untouched", mem[32'h100 >> 2], 32'h0);
        check("R11 unavail held", buf_unavail, 1);
        poke(32'h100, 32'h8000_0000);
        @(negedge clk); poll_demand = 1'b1;
        @(negedge clk); poll_demand = 1'b0;
        wait_cycles(20);
        check("R11 unavail cleared by poll", buf_unavail, 0);
        run_frame(11, 2'd2, 5'd0, "R11 after poll");

        // random frames
        setup_ring(32'h200, 32'h400, 4, 16, 1'b0, 1'b1);
        for (int f = 0; f < 14; f++) begin
            int len;
            logic [1:0] m;
            logic [4:0] e;
            len = 1 + ($urandom % 40);
            m = 2'($urandom);
            e = (($urandom % 3) == 0) ? 5'($urandom) : 5'd0;
            run_frame(len, m, e, "random R9");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule